// File: doc/BRIEF.md
# Cross-Coupled GPIO Line Pair Bank

This block models two GPIO banks, side A and side B, whose lines are joined one to one. Line i of side A and line i of side B sit on the same virtual net, and a weak pull-down holds that net low. Each side keeps a direction bit and a drive-value bit for every line. The block resolves the level each line sees and presents it as one level vector per side. Software-style control comes through a single write channel. That channel carries a side mask, a line offset, an operation code and a value bit.

A line that drives reads back its own drive value. A line that listens reads its partner's drive value when the partner drives, and reads 0 otherwise. The resolved vectors are registered. They change at the same clock edge that captures the write, so they are visible one cycle after the write is presented. A combinational read-back port returns the direction bit and the resolved level of any single line on either side.

Operation codes on `wr_op`: 2'b00 store-value, which changes only the stored drive value. 2'b01 drive, which sets the value and direction=output in one step. 2'b10 float, which sets direction=input and keeps the stored value. 2'b11 enable, which sets direction=output and uses the stored value.

Top module: `gpio_pair_bank`

## Requirements
- R1: While reset is asserted, and immediately after reset, every direction bit, every drive-value bit and every resolved level on both sides is 0.
- R2: When both lines of a pair are inputs, both read 0, whatever values they have stored.
- R3: A line whose direction bit is 1 (output) reads its own drive value, whatever its partner does.
- R4: A line whose direction bit is 0 (input) reads its partner's drive value when the partner is an output.
- R5: The drive operation (2'b01) sets the value and the direction in the same edge. The written line shows the new value on the very next cycle, with no intermediate level.
- R6: The store-value operation (2'b00) on an input line leaves both level vectors unchanged. A later enable operation (2'b11) makes the stored value visible.
- R7: `rd_dir` and `rd_level` return the direction bit and the resolved level of line `rd_off` on side `rd_port`, where 0 selects A and 1 selects B.
- R8: Bit 0 of `wr_sel` selects side A and bit 1 selects side B. When both bits are set, both sides take the write in the same edge, and the levels reflect both writes one cycle later. When neither bit is set, nothing changes.
- R9: A write touches only line `wr_off`. Every other line keeps its level, and with `wr_valid` low no level changes.
- R10: Direction bit encoding is 1 = output and 0 = input, and it reads back through `rd_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write strobe |
| wr_sel | input | 2 | Side mask: bit 0 = A, bit 1 = B |
| wr_op | input | 2 | Operation code |
| wr_off | input | OFFW (5) | Line offset |
| wr_val | input | 1 | Value bit for store-value and drive |
| rd_port | input | 1 | Read-back side: 0 = A, 1 = B |
| rd_off | input | OFFW (5) | Read-back line offset |
| rd_dir | output | 1 | Direction bit of the selected line |
| rd_level | output | 1 | Resolved level of the selected line |
| level_a | output | LINES (32) | Resolved levels, side A |
| level_b | output | LINES (32) | Resolved levels, side B |

## Verification
The bench builds the block with its default of 32 lines, so the offset is 5 bits wide. This puts the top line, offset 31, within reach alongside offsets 0 and 3. That is enough to show that the write mask and the read-back mux reach both ends of the vector. It is also enough to show that neighbouring lines stay untouched. The stimulus table walks one pair through every direction combination and all four operation codes, with both-side and empty side masks included.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    typedef enum logic [1:0] {
        OP_STORE  = 2'b00,
        OP_DRIVE  = 2'b01,
        OP_FLOAT  = 2'b10,
        OP_ENABLE = 2'b11
    } gpb_op_e;

    localparam int SIDES = 2;

endpackage

// File: rtl/gpb_side_regs.sv
module gpb_side_regs #(
    parameter int LINES = 32,
    localparam int OFFW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  gpb_pkg::gpb_op_e op,
    input  logic [OFFW-1:0]  off,
    input  logic             val,
    output logic [LINES-1:0] dir_nxt,
    output logic [LINES-1:0] val_nxt,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] val_q
);
    import gpb_pkg::*;

    logic [LINES-1:0] sel_mask;

    assign sel_mask = {{(LINES-1){1'b0}}, 1'b1} << off;

    // Next-state decode: only the addressed line may change.
    always_comb begin
        dir_nxt = dir_q;
        val_nxt = val_q;
        if (we) begin
            unique case (op)
                OP_STORE: begin
                    val_nxt = val ? (val_q | sel_mask) : (val_q & ~sel_mask);
                end
                OP_DRIVE: begin
                    val_nxt = val ? (val_q | sel_mask) : (val_q & ~sel_mask);
                    dir_nxt = dir_q | sel_mask;
                end
                OP_FLOAT: begin
                    dir_nxt = dir_q & ~sel_mask;
                end
                OP_ENABLE: begin
                    dir_nxt = dir_q | sel_mask;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            val_q <= '0;
        end else begin
            dir_q <= dir_nxt;
            val_q <= val_nxt;
        end
    end

endmodule

// File: rtl/gpb_resolve.sv
module gpb_resolve #(
    parameter int LINES = 32
) (
    input  logic [LINES-1:0] dir_a,
    input  logic [LINES-1:0] val_a,
    input  logic [LINES-1:0] dir_b,
    input  logic [LINES-1:0] val_b,
    output logic [LINES-1:0] lvl_a,
    output logic [LINES-1:0] lvl_b
);
    // One net per pair: an own output wins, else the partner's output, else pull-down.
    for (genvar i = 0; i < LINES; i++) begin : g_pair
        always_comb begin
            if (dir_a[i])      lvl_a[i] = val_a[i];
            else if (dir_b[i]) lvl_a[i] = val_b[i];
            else               lvl_a[i] = 1'b0;

            if (dir_b[i])      lvl_b[i] = val_b[i];
            else if (dir_a[i]) lvl_b[i] = val_a[i];
            else               lvl_b[i] = 1'b0;
        end
    end

endmodule

// File: rtl/gpio_pair_bank.sv
module gpio_pair_bank #(
    parameter int LINES = 32,
    localparam int OFFW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [1:0]       wr_sel,
    input  logic [1:0]       wr_op,
    input  logic [OFFW-1:0]  wr_off,
    input  logic             wr_val,
    input  logic             rd_port,
    input  logic [OFFW-1:0]  rd_off,
    output logic             rd_dir,
    output logic             rd_level,
    output logic [LINES-1:0] level_a,
    output logic [LINES-1:0] level_b
);
    import gpb_pkg::*;

    gpb_op_e          op;
    logic [LINES-1:0] dir_nxt [SIDES];
    logic [LINES-1:0] val_nxt [SIDES];
    logic [LINES-1:0] dir_q   [SIDES];
    logic [LINES-1:0] val_q   [SIDES];
    logic [LINES-1:0] lvl_nxt_a;
    logic [LINES-1:0] lvl_nxt_b;
    logic [LINES-1:0] dir_vec_a;
    logic [LINES-1:0] dir_vec_b;

    assign op = gpb_op_e'(wr_op);

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        gpb_side_regs #(.LINES(LINES)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_valid && wr_sel[s]),
            .op      (op),
            .off     (wr_off),
            .val     (wr_val),
            .dir_nxt (dir_nxt[s]),
            .val_nxt (val_nxt[s]),
            .dir_q   (dir_q[s]),
            .val_q   (val_q[s])
        );
    end

    // Resolve from the post-write state so both sides' writes land together.
    gpb_resolve #(.LINES(LINES)) u_resolve (
        .dir_a (dir_nxt[0]),
        .val_a (val_nxt[0]),
        .dir_b (dir_nxt[1]),
        .val_b (val_nxt[1]),
        .lvl_a (lvl_nxt_a),
        .lvl_b (lvl_nxt_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_a <= '0;
            level_b <= '0;
        end else begin
            level_a <= lvl_nxt_a;
            level_b <= lvl_nxt_b;
        end
    end

    assign dir_vec_a = dir_q[0];
    assign dir_vec_b = dir_q[1];

    always_comb begin
        if (rd_port) begin
            rd_dir   = dir_vec_b[rd_off];
            rd_level = level_b[rd_off];
        end else begin
            rd_dir   = dir_vec_a[rd_off];
            rd_level = level_a[rd_off];
        end
    end

endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
    parameter int LINES = 32,
    localparam int OFFW = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [1:0]       wr_sel,
    input logic [1:0]       wr_op,
    input logic [OFFW-1:0]  wr_off,
    input logic             wr_val,
    input logic [LINES-1:0] level_a,
    input logic [LINES-1:0] level_b,
    input logic [LINES-1:0] dir_a,
    input logic [LINES-1:0] dir_b
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (level_a == '0 && level_b == '0 && dir_a == '0 && dir_b == '0));

    // R2
    a_r2_float_pair_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_a & ~dir_b & (level_a | level_b)) == '0));

    // R5
    a_r5_drive_lands_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel[0] && wr_op == 2'b01)
        |=> (level_a[$past(wr_off)] == $past(wr_val)));

    // R8
    a_r8_dual_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 2'b11 && wr_op == 2'b01)
        |=> (level_a[$past(wr_off)] == $past(wr_val) && level_b[$past(wr_off)] == $past(wr_val)));

    // R6
    a_r6_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == 2'b01 && wr_op == 2'b00 && !dir_a[wr_off])
        |=> ($stable(level_a) && $stable(level_b)));

    // R9
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid || wr_sel == 2'b00) |=> ($stable(level_a) && $stable(level_b)));

endmodule

bind gpio_pair_bank gpb_checker #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_op    (wr_op),
    .wr_off   (wr_off),
    .wr_val   (wr_val),
    .level_a  (level_a),
    .level_b  (level_b),
    .dir_a    (dir_vec_a),
    .dir_b    (dir_vec_b)
);

// File: tb/sim_gpio_pair_bank.sv
module sim_gpio_pair_bank;

    localparam int CLK_PERIOD = 10;
    localparam int LINES = 32;
    localparam int OFFW = 5;
    localparam int NVEC = 12;

    // {sel[1:0], op[1:0], off[4:0], val, exp_a, exp_b}
    localparam logic [11:0] VEC [NVEC] = '{
        {2'b01, 2'b00, 5'd3,  1'b1, 1'b0, 1'b0},  // R6 store on input: no change
        {2'b01, 2'b11, 5'd3,  1'b0, 1'b1, 1'b1},  // R6 enable shows stored 1, R4 B reads it
        {2'b10, 2'b01, 5'd3,  1'b0, 1'b1, 1'b0},  // R3 both drive, each reads own
        {2'b01, 2'b10, 5'd3,  1'b0, 1'b0, 1'b0},  // R4 A floats, reads B's 0
        {2'b10, 2'b00, 5'd3,  1'b1, 1'b1, 1'b1},  // R4 B output value 1 seen by A
        {2'b10, 2'b10, 5'd3,  1'b0, 1'b0, 1'b0},  // R2 both inputs read 0
        {2'b11, 2'b01, 5'd31, 1'b1, 1'b1, 1'b1},  // R8 both sides in one write
        {2'b01, 2'b01, 5'd31, 1'b0, 1'b0, 1'b1},  // R3 R5 A drives 0, B keeps 1
        {2'b10, 2'b10, 5'd31, 1'b0, 1'b0, 1'b0},  // R4 B floats, reads A's 0
        {2'b01, 2'b00, 5'd31, 1'b1, 1'b1, 1'b1},  // R3 store on output shows at once
        {2'b00, 2'b01, 5'd0,  1'b1, 1'b0, 1'b0},  // R8 empty mask: nothing
        {2'b10, 2'b01, 5'd0,  1'b1, 1'b1, 1'b1}   // R5 drive on B
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic [1:0]       wr_sel = '0;
    logic [1:0]       wr_op = '0;
    logic [OFFW-1:0]  wr_off = '0;
    logic             wr_val = 1'b0;
    logic             rd_port = 1'b0;
    logic [OFFW-1:0]  rd_off = '0;
    logic             rd_dir;
    logic             rd_level;
    logic [LINES-1:0] level_a;
    logic [LINES-1:0] level_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pair_bank #(.LINES(LINES)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_op(wr_op), .wr_off(wr_off), .wr_val(wr_val), .rd_port(rd_port),
        .rd_off(rd_off), .rd_dir(rd_dir), .rd_level(rd_level),
        .level_a(level_a), .level_b(level_b)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [1:0] op,
                            input logic [OFFW-1:0] off, input logic val);
        @(negedge clk);
        wr_valid = 1'b1; wr_sel = sel; wr_op = op; wr_off = off; wr_val = val;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic port, input logic [OFFW-1:0] off);
        rd_port = port; rd_off = off;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: during reset
        check("R1", {level_a, level_b}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, 5'd3);
        check("R1", {62'h0, rd_dir, rd_level}, 64'h0);

        for (int k = 0; k < NVEC; k++) begin
            do_write(VEC[k][11:10], VEC[k][9:8], VEC[k][7:3], VEC[k][2]);
            check($sformatf("R2-R6/R8 vec%0d side A", k), {63'h0, level_a[VEC[k][7:3]]}, {63'h0, VEC[k][1]});
            check($sformatf("R2-R6/R8 vec%0d side B", k), {63'h0, level_b[VEC[k][7:3]]}, {63'h0, VEC[k][0]});
        end

        // R9: untouched lines stay low; full vectors
        check("R9", {32'h0, level_a}, {32'h0, 32'h8000_0001});
        check("R9", {32'h0, level_b}, {32'h0, 32'h8000_0001});

        // R7 R10: read-back
        rd(1'b1, 5'd0);
        check("R7 R10 B0", {62'h0, rd_dir, rd_level}, {62'h0, 2'b11});
        rd(1'b0, 5'd0);
        check("R7 R10 A0", {62'h0, rd_dir, rd_level}, {62'h0, 2'b01});
        rd(1'b1, 5'd31);
        check("R7 R10 B31", {62'h0, rd_dir, rd_level}, {62'h0, 2'b01});
        rd(1'b0, 5'd3);
        check("R7 A3", {62'h0, rd_dir, rd_level}, {62'h0, 2'b00});

        // R9: strobe low with other fields active changes nothing
        @(negedge clk);
        wr_sel = 2'b11; wr_op = 2'b01; wr_off = 5'd7; wr_val = 1'b1;
        @(negedge clk);
        check("R9 idle", {level_a, level_b}, {32'h8000_0001, 32'h8000_0001});

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        #1;
        check("R1 async", {level_a, level_b}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(1'b1, 5'd0);
        check("R1 R10 dir cleared", {62'h0, rd_dir, rd_level}, 64'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule